// File: doc/BRIEF.md
# Refresh Timer with Command Window

This block paces periodic auto-refresh for a single-rank SDRAM controller clocked at 100 MHz. It stays silent until the power-up sequence reports completion. From then on it counts clock cycles, and when a full refresh interval has elapsed it raises a refresh request toward the controller's main state machine. The request stays up until the refresh engine signals that a refresh has finished.

Any completed refresh restarts the interval, whether it was timed or forced by the controller after a long read or write burst. So the next timed refresh always falls one full interval after the last real one. The block also drives a command window that is open only during the first stretch of each interval. The main state machine admits a new burst only while the window is open. A burst of about 6 µs started early in a 7.7 µs interval then ends well before the 7.8125 µs hard deadline.

Top module: `refresh_scheduler`

## Requirements
- R1: An active-low asynchronous reset (rst_ni low) forces ref_req_o and cmd_win_o low at once and returns the block to its unarmed state, in which it waits again for init_done_i.
- R2: Until init_done_i has been sampled high at a clock edge, ref_req_o and cmd_win_o stay low, and pulses on ref_done_i have no effect.
- R3: After the arming edge (the first edge with init_done_i high), ref_req_o rises exactly REF_PERIOD clock edges later if no refresh completes in between. The default REF_PERIOD is 770, which is 7.7 µs at 100 MHz.
- R4: Once high, ref_req_o stays high on every following edge until an edge samples ref_done_i high. ref_req_o is low after that edge.
- R5: An edge that samples ref_done_i high while the block is armed restarts the interval. The next request rises exactly REF_PERIOD edges after that edge, whether or not a request was pending.
- R6: When ref_done_i is high on the edge at which the interval would expire (REF_PERIOD-1 edges after the restart), the done pulse wins. No request is raised, and the interval restarts from zero.
- R7: cmd_win_o is high exactly while the block is armed, no request is pending, and fewer than WIN_LEN edges have passed since the last restart or the arming edge. The default WIN_LEN is 100 (1 µs). cmd_win_o is never high together with ref_req_o.
- R8: Once armed, the block ignores a later drop of init_done_i, and timing continues unchanged.
- R9: The window reopens for WIN_LEN edges after every completed refresh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Controller clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| init_done_i | input | 1 | Power-up initialization complete |
| ref_done_i | input | 1 | One-cycle pulse: a refresh has finished |
| ref_req_o | output | 1 | Auto-refresh request, held until ref_done_i |
| cmd_win_o | output | 1 | High while a new read/write burst may be admitted |

## Verification
The bench builds the block with REF_PERIOD=20 and WIN_LEN=5 instead of 770 and 100. This keeps every interval short, so one run covers the window edges at counts 4 and 5, the expiry edge at count 19 and the request at 20. It also covers a done pulse landing on the expiry edge and a reset taken while a request is pending. All expected levels follow from edge counts since the last restart.

// File: rtl/refresh_sched_pkg.sv
package refresh_sched_pkg;
  typedef enum logic [1:0] {
    PH_WAIT = 2'd0,  // not yet armed
    PH_RUN  = 2'd1,  // interval running
    PH_PEND = 2'd2   // request pending
  } phase_e;
endpackage

// File: rtl/rs_interval_cnt.sv
module rs_interval_cnt #(
  parameter int unsigned REF_PERIOD = 770,
  localparam int unsigned CNT_W = (REF_PERIOD > 2) ? $clog2(REF_PERIOD) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             clear_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             tc_o
);
  localparam logic [CNT_W-1:0] TC_VAL = CNT_W'(REF_PERIOD - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (!run_i)      cnt_q <= '0;
    else if (clear_i)     cnt_q <= '0;
    else if (cnt_q != TC_VAL) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;
  assign tc_o  = run_i && (cnt_q == TC_VAL);

  // R5
  cnt_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && clear_i) |=> (cnt_o == '0));

  // R4
  tc_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tc_o && !clear_i && run_i) |=> (cnt_o == TC_VAL));
endmodule

// File: rtl/rs_phase_ctrl.sv
module rs_phase_ctrl
  import refresh_sched_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   init_done_i,
  input  logic   ref_done_i,
  input  logic   tc_i,
  output phase_e phase_o
);
  phase_e phase_q, phase_d;

  always_comb begin
    phase_d = phase_q;
    unique case (phase_q)
      PH_WAIT: if (init_done_i) phase_d = PH_RUN;
      PH_RUN:  if (!ref_done_i && tc_i) phase_d = PH_PEND;  // done beats expiry
      PH_PEND: if (ref_done_i) phase_d = PH_RUN;
      default: phase_d = PH_WAIT;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) phase_q <= PH_WAIT;
    else         phase_q <= phase_d;
  end

  assign phase_o = phase_q;

  // R4
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_PEND && !ref_done_i) |=> (phase_q == PH_PEND));

  // R3
  req_raise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_RUN && tc_i && !ref_done_i) |=> (phase_q == PH_PEND));

  // R6
  done_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q != PH_WAIT && ref_done_i) |=> (phase_q == PH_RUN));

  // R8
  arm_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q != PH_WAIT) |=> (phase_q != PH_WAIT));
endmodule

// File: rtl/rs_window_dec.sv
module rs_window_dec #(
  parameter int unsigned WIN_LEN = 100,
  parameter int unsigned CNT_W   = 10
) (
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             counting_i,
  output logic             win_o
);
  localparam logic [CNT_W-1:0] WIN_LIM = CNT_W'(WIN_LEN);

  assign win_o = counting_i && (cnt_i < WIN_LIM);
endmodule

// File: rtl/refresh_scheduler.sv
module refresh_scheduler
  import refresh_sched_pkg::*;
#(
  parameter int unsigned REF_PERIOD = 770,
  parameter int unsigned WIN_LEN    = 100
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic init_done_i,
  input  logic ref_done_i,
  output logic ref_req_o,
  output logic cmd_win_o
);
  localparam int unsigned CNT_W = (REF_PERIOD > 2) ? $clog2(REF_PERIOD) : 1;

  phase_e           phase;
  logic [CNT_W-1:0] cnt;
  logic             tc;
  logic             armed;

  assign armed = (phase != PH_WAIT);

  rs_phase_ctrl u_phase (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .init_done_i (init_done_i),
    .ref_done_i  (ref_done_i),
    .tc_i        (tc),
    .phase_o     (phase)
  );

  rs_interval_cnt #(.REF_PERIOD(REF_PERIOD)) u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .run_i   (armed),
    .clear_i (ref_done_i),
    .cnt_o   (cnt),
    .tc_o    (tc)
  );

  rs_window_dec #(.WIN_LEN(WIN_LEN), .CNT_W(CNT_W)) u_win (
    .cnt_i      (cnt),
    .counting_i (phase == PH_RUN),
    .win_o      (cmd_win_o)
  );

  assign ref_req_o = (phase == PH_PEND);

  // R7
  win_vs_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ref_req_o |-> !cmd_win_o);

  // R2
  unarmed_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !armed |-> (!ref_req_o && !cmd_win_o && cnt == '0));

  // R9
  win_reopen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed && ref_done_i) |=> cmd_win_o);
endmodule

// File: tb/refresh_scheduler_tb_top.sv
module refresh_scheduler_tb_top;
  localparam int unsigned P = 20;
  localparam int unsigned W = 5;
  localparam int NV = 7;
  localparam int GAP [NV]     = '{0, 3, 4, 5, 19, 20, 25};
  localparam bit EXP_REQ [NV] = '{0, 0, 0, 0, 0,  1,  1};
  localparam bit EXP_WIN [NV] = '{1, 1, 1, 0, 0,  0,  0};

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic init_done = 1'b0;
  logic ref_done = 1'b0;
  logic ref_req, cmd_win;
  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  refresh_scheduler #(.REF_PERIOD(P), .WIN_LEN(W)) dut_i (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .init_done_i (init_done),
    .ref_done_i  (ref_done),
    .ref_req_o   (ref_req),
    .cmd_win_o   (cmd_win)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic pulse_done();
    ref_done = 1'b1;
    @(negedge clk);
    ref_done = 1'b0;
  endtask

  initial begin
    #(4 * 50000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #1;
    chk("R1 reset req", ref_req, 1'b0);
    chk("R1 reset win", cmd_win, 1'b0);
    wait_n(3);
    rst_ni = 1'b1;
    wait_n(5);
    pulse_done();
    wait_n(P + 5);
    chk("R2 unarmed req", ref_req, 1'b0);
    chk("R2 unarmed win", cmd_win, 1'b0);

    // arm
    init_done = 1'b1;
    @(negedge clk);
    init_done = 1'b0;  // R8: drop ignored
    chk("R7 win after arm", cmd_win, 1'b1);
    wait_n(P - 1);
    chk("R3 no req at P-1", ref_req, 1'b0);
    wait_n(1);
    chk("R3 req at P", ref_req, 1'b1);
    chk("R8 timing kept after init drop", ref_req, 1'b1);
    wait_n(10);
    chk("R4 req held", ref_req, 1'b1);
    chk("R7 win closed while req", cmd_win, 1'b0);

    // table walk: each vector restarts then checks after a gap
    for (int i = 0; i < NV; i++) begin
      pulse_done();
      chk("R9 win after done", cmd_win, 1'b1);
      wait_n(GAP[i]);
      chk($sformatf("R5 req gap %0d", GAP[i]), ref_req, EXP_REQ[i]);
      chk($sformatf("R7 win gap %0d", GAP[i]), cmd_win, EXP_WIN[i]);
    end

    // R4: done drops pending request
    pulse_done();
    chk("R4 req dropped", ref_req, 1'b0);

    // R6: done on expiry edge
    wait_n(P - 1);
    chk("R6 pre-expiry req", ref_req, 1'b0);
    pulse_done();
    chk("R6 done wins req", ref_req, 1'b0);
    chk("R6 window reopened", cmd_win, 1'b1);
    wait_n(P - 1);
    chk("R6 restart no early req", ref_req, 1'b0);
    wait_n(1);
    chk("R6 restart req at P", ref_req, 1'b1);

    // R1: asynchronous reset while pending
    rst_ni = 1'b0;
    #1;
    chk("R1 async req", ref_req, 1'b0);
    chk("R1 async win", cmd_win, 1'b0);
    @(negedge clk);
    rst_ni = 1'b1;
    wait_n(P + 3);
    chk("R1 rearm needed req", ref_req, 1'b0);
    chk("R1 rearm needed win", cmd_win, 1'b0);
    init_done = 1'b1;
    @(negedge clk);
    chk("R2 armed again win", cmd_win, 1'b1);
    wait_n(W);
    chk("R7 window closes at W", cmd_win, 1'b0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule